// File: doc/BRIEF.md
# Flash mailbox command validator

This block sits between a mailbox that delivers 32-bit command words and a serial-flash controller. A command arrives as a header word followed by argument words, with `in_last` marking the final word. The block recognises four flash commands: data write, sector erase, device-register read and device-register write. It collects the arguments and stores write payload words in a small local buffer. It then checks the argument count and each field rule for the command. When every check passes it raises a request to the downstream controller. When a check fails it answers at once with an error header and sends nothing downstream.

Once the downstream controller signals completion, the block emits a response header. For a register read, the header is followed by the returned bytes packed into 32-bit words. Bytes beyond the requested count are forced to zero, so a partial final word is padded. The controller reads stored payload words through a separate buffer read port.

Top module: `flash_cmd_validator`

## Requirements
- R1: The command header carries the command code in bits [11:0] and the declared argument word count in bits [22:12]. The response header carries the error code in bits [10:0] (0 = OK), zero in bit 11, the number of data words that follow in bits [22:12], and zero in bits [31:23].
- R2: A code other than 0x039 (write), 0x038 (erase), 0x035 (register read) or 0x036 (register write), or a header with nonzero bits [31:23], is answered with error 0x3FF and zero data words. This check wins over every other check.
- R3: When the declared argument count differs from the count received, the response is error 0x100 and nothing is forwarded. This check is second in priority.
- R4: A write whose address argument has nonzero bits [1:0] is rejected with error 0x3FF.
- R5: A write must carry at least one data word. With fewer than three arguments the response is error 0x100. A word count of zero or above DATA_DEPTH gives error 0x105. A word count that differs from the number of data words gives error 0x100.
- R6: An erase whose start address has nonzero bits [15:0] is rejected with error 0x101. An erase must carry exactly two arguments.
- R7: An erase length of zero, or one that is not a multiple of 0x4000 words, is rejected with error 0x102.
- R8: A register read or register write byte count of 0 or above 8 gives error 0x103. A register read must carry exactly two arguments. A register write must carry ceil(bytes/4) data words after its two arguments, or the response is error 0x100.
- R9: While `cfg_busy` is high in the check cycle, writes and register writes are refused with error 0x104 and not forwarded. This check ranks after R2 and R3 and before the field checks. Erase and register read are not affected by `cfg_busy`.
- R10: A valid command raises `dn_req` and holds it until `dn_done`. It presents the command code on `dn_cmd` and the first two arguments on `dn_arg0` and `dn_arg1`. Payload data word j can be read at buffer address j, with `dn_buf_data` valid one cycle after `dn_buf_addr`.
- R11: A successful register read returns an OK header with a count of ceil(bytes/4), followed by that many words. Byte i of `dn_rdata` (bits [8i+7:8i]) goes to word i/4 at byte lane i%4. Every byte at or beyond the requested count is zero.
- R12: `in_ready` is low from the cycle after a command's last word is accepted until the response is complete. Response words appear on consecutive cycles, with `rsp_last` on the final one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_busy | input | 1 | Configuration in progress; refuses writes |
| in_valid | input | 1 | Mailbox word valid |
| in_data | input | 32 | Mailbox word |
| in_last | input | 1 | Final word of the command |
| in_ready | output | 1 | Block accepts a mailbox word |
| rsp_valid | output | 1 | Response word valid |
| rsp_data | output | 32 | Response header or data word |
| rsp_last | output | 1 | Final response word |
| dn_req | output | 1 | Request to the flash controller |
| dn_cmd | output | 12 | Validated command code |
| dn_arg0 | output | 32 | First argument (address or device opcode) |
| dn_arg1 | output | 32 | Second argument (length or byte count) |
| dn_done | input | 1 | Controller finished the request |
| dn_rdata | input | 8*MAX_REG_BYTES | Bytes read from a device register, byte 0 lowest |
| dn_buf_addr | input | clog2(DATA_DEPTH) | Payload buffer read address |
| dn_buf_data | output | 32 | Payload buffer read data, one cycle latency |

## Verification
The bench targets the check priorities. An unknown code with a wrong count must still report 0x3FF. A busy write with a misaligned address must report the busy error. A design that ordered the checks differently would return the wrong code. Erase addresses that are half a sector off and lengths one word past the granularity probe the alignment masks: a mask one bit short would forward a bad erase. Register reads of 1, 3, 5 and 8 bytes expose any padding fault, which would leak stale upper bytes into the last word. A write of the full buffer depth shows whether the last payload word is lost or the count limit is off by one. A reset in the middle of a command shows whether leftover collection state corrupts the next command.

// File: rtl/fcv_pkg.sv
package fcv_pkg;
  localparam logic [11:0] OP_WRITE = 12'h039;
  localparam logic [11:0] OP_ERASE = 12'h038;
  localparam logic [11:0] OP_RDREG = 12'h035;
  localparam logic [11:0] OP_WRREG = 12'h036;

  localparam logic [10:0] E_OK     = 11'h000;
  localparam logic [10:0] E_BADCMD = 11'h3FF;
  localparam logic [10:0] E_LEN    = 11'h100;
  localparam logic [10:0] E_SECTOR = 11'h101;
  localparam logic [10:0] E_ERLEN  = 11'h102;
  localparam logic [10:0] E_BYTES  = 11'h103;
  localparam logic [10:0] E_BUSY   = 11'h104;
  localparam logic [10:0] E_WCOUNT = 11'h105;

  typedef enum logic [1:0] {ST_IN, ST_CHK, ST_DN, ST_DAT} fsm_t;

  function automatic logic [31:0] mk_rsp(input logic [10:0] err, input logic [10:0] cnt);
    return {9'b0, cnt, 1'b0, err};
  endfunction
endpackage

// File: rtl/fcv_collect.sv
module fcv_collect #(
  parameter int DEPTH = 16,
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        take,
  input  logic [31:0] word,
  input  logic        last,
  output logic [11:0] hdr_code,
  output logic [10:0] hdr_len,
  output logic [8:0]  hdr_rsv,
  output logic [10:0] nargs,
  output logic [31:0] arg0,
  output logic [31:0] arg1,
  output logic        wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0] wr_data
);
  localparam logic [10:0] NSAT = 11'h7FF;

  logic        in_hdr;
  logic [10:0] didx;

  assign didx    = nargs - 11'd2;
  assign wr_en   = take && !in_hdr && (nargs >= 11'd2) && (didx < 11'(DEPTH));
  assign wr_addr = didx[AW-1:0];
  assign wr_data = word;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_hdr   <= 1'b1;
      hdr_code <= '0;
      hdr_len  <= '0;
      hdr_rsv  <= '0;
      nargs    <= '0;
      arg0     <= '0;
      arg1     <= '0;
    end else if (take) begin
      in_hdr <= last;
      if (in_hdr) begin
        hdr_code <= word[11:0];
        hdr_len  <= word[22:12];
        hdr_rsv  <= word[31:23];
        nargs    <= '0;
        arg0     <= '0;
        arg1     <= '0;
      end else begin
        if (nargs == 11'd0) arg0 <= word;
        if (nargs == 11'd1) arg1 <= word;
        if (nargs != NSAT) nargs <= nargs + 11'd1;
      end
    end
  end
endmodule

// File: rtl/fcv_buf.sv
module fcv_buf #(
  parameter int DEPTH = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [31:0]   wd,
  input  logic [AW-1:0] ra,
  output logic [31:0]   rd
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/fcv_rules.sv
module fcv_rules
  import fcv_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int MAXB = 8,
  parameter int CW = 4,
  parameter int SECT_BITS = 16,
  parameter int GRAN_BITS = 14
) (
  input  logic [11:0]          code,
  input  logic [8:0]           rsv,
  input  logic [10:0]          hdr_len,
  input  logic [10:0]          nargs,
  input  logic [SECT_BITS-1:0] arg0_lo,
  input  logic [31:0]          arg1,
  input  logic                 busy,
  output logic [10:0]          err,
  output logic [10:0]          rd_words
);
  logic known, bytes_bad, is_wr;

  assign known     = (code == OP_WRITE) || (code == OP_ERASE) ||
                     (code == OP_RDREG) || (code == OP_WRREG);
  assign is_wr     = (code == OP_WRITE) || (code == OP_WRREG);
  assign bytes_bad = (arg1 == 32'd0) || (arg1 > 32'(MAXB));
  assign rd_words  = (11'(arg1[CW-1:0]) + 11'd3) >> 2;

  always_comb begin
    err = E_OK;
    if (!known || rsv != 9'd0)       err = E_BADCMD;
    else if (hdr_len != nargs)       err = E_LEN;
    else if (busy && is_wr)          err = E_BUSY;
    else begin
      unique case (code)
        OP_WRITE: begin
          if (nargs < 11'd3)                               err = E_LEN;
          else if (arg0_lo[1:0] != 2'b00)                  err = E_BADCMD;
          else if (arg1 == 32'd0 || arg1 > 32'(DEPTH))     err = E_WCOUNT;
          else if (arg1[10:0] != nargs - 11'd2)            err = E_LEN;
        end
        OP_ERASE: begin
          if (nargs != 11'd2)                              err = E_LEN;
          else if (arg0_lo != '0)                          err = E_SECTOR;
          else if (arg1 == 32'd0 || arg1[GRAN_BITS-1:0] != '0) err = E_ERLEN;
        end
        OP_RDREG: begin
          if (nargs != 11'd2)                              err = E_LEN;
          else if (bytes_bad)                              err = E_BYTES;
        end
        default: begin
          if (nargs < 11'd2)                               err = E_LEN;
          else if (bytes_bad)                              err = E_BYTES;
          else if (nargs - 11'd2 != rd_words)              err = E_LEN;
        end
      endcase
    end
  end
endmodule

// File: rtl/fcv_pack.sv
module fcv_pack #(
  parameter int MAXB = 8,
  parameter int CW = 4
) (
  input  logic [MAXB*8-1:0] raw,
  input  logic [CW-1:0]     nbytes,
  output logic [MAXB*8-1:0] packed_out
);
  for (genvar g = 0; g < MAXB; g++) begin : g_lane
    assign packed_out[8*g +: 8] = (CW'(g) < nbytes) ? raw[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/flash_cmd_validator.sv
module flash_cmd_validator
  import fcv_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  parameter int MAX_REG_BYTES = 8,
  parameter int SECT_BITS = 16,
  parameter int GRAN_BITS = 14,
  localparam int AW = (DATA_DEPTH > 1) ? $clog2(DATA_DEPTH) : 1,
  localparam int CW = $clog2(MAX_REG_BYTES + 1),
  localparam int WPR = MAX_REG_BYTES / 4,
  localparam int WW = (WPR > 1) ? $clog2(WPR) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_busy,
  input  logic                       in_valid,
  input  logic [31:0]                in_data,
  input  logic                       in_last,
  output logic                       in_ready,
  output logic                       rsp_valid,
  output logic [31:0]                rsp_data,
  output logic                       rsp_last,
  output logic                       dn_req,
  output logic [11:0]                dn_cmd,
  output logic [31:0]                dn_arg0,
  output logic [31:0]                dn_arg1,
  input  logic                       dn_done,
  input  logic [MAX_REG_BYTES*8-1:0] dn_rdata,
  input  logic [AW-1:0]              dn_buf_addr,
  output logic [31:0]                dn_buf_data
);
  fsm_t state;

  logic        take;
  logic [11:0] c_code;
  logic [10:0] c_len, c_nargs;
  logic [8:0]  c_rsv;
  logic [31:0] c_a0, c_a1;
  logic        b_we;
  logic [AW-1:0] b_wa;
  logic [31:0] b_wd;
  logic [10:0] chk_err, chk_words;
  logic [MAX_REG_BYTES*8-1:0] packed_rd, rd_hold;
  logic [31:0] hold_w [WPR];
  logic [10:0] rsp_cnt;
  logic [WW-1:0] widx;

  assign in_ready = (state == ST_IN);
  assign take     = in_valid && in_ready;

  fcv_collect #(.DEPTH(DATA_DEPTH), .AW(AW)) u_collect (
    .clk(clk), .rst(rst), .take(take), .word(in_data), .last(in_last),
    .hdr_code(c_code), .hdr_len(c_len), .hdr_rsv(c_rsv), .nargs(c_nargs),
    .arg0(c_a0), .arg1(c_a1), .wr_en(b_we), .wr_addr(b_wa), .wr_data(b_wd)
  );

  fcv_buf #(.DEPTH(DATA_DEPTH), .AW(AW)) u_buf (
    .clk(clk), .we(b_we), .wa(b_wa), .wd(b_wd), .ra(dn_buf_addr), .rd(dn_buf_data)
  );

  fcv_rules #(.DEPTH(DATA_DEPTH), .MAXB(MAX_REG_BYTES), .CW(CW),
              .SECT_BITS(SECT_BITS), .GRAN_BITS(GRAN_BITS)) u_rules (
    .code(c_code), .rsv(c_rsv), .hdr_len(c_len), .nargs(c_nargs),
    .arg0_lo(c_a0[SECT_BITS-1:0]), .arg1(c_a1), .busy(cfg_busy),
    .err(chk_err), .rd_words(chk_words)
  );

  fcv_pack #(.MAXB(MAX_REG_BYTES), .CW(CW)) u_pack (
    .raw(dn_rdata), .nbytes(dn_arg1[CW-1:0]), .packed_out(packed_rd)
  );

  for (genvar g = 0; g < WPR; g++) begin : g_word
    assign hold_w[g] = rd_hold[32*g +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IN;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_last  <= 1'b0;
      dn_req    <= 1'b0;
      dn_cmd    <= '0;
      dn_arg0   <= '0;
      dn_arg1   <= '0;
      rd_hold   <= '0;
      rsp_cnt   <= '0;
      widx      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      unique case (state)
        ST_IN: if (take && in_last) state <= ST_CHK;
        ST_CHK: begin
          if (chk_err != E_OK) begin
            rsp_valid <= 1'b1;
            rsp_data  <= mk_rsp(chk_err, 11'd0);
            rsp_last  <= 1'b1;
            state     <= ST_IN;
          end else begin
            dn_req  <= 1'b1;
            dn_cmd  <= c_code;
            dn_arg0 <= c_a0;
            dn_arg1 <= c_a1;
            rsp_cnt <= (c_code == OP_RDREG) ? chk_words : 11'd0;
            state   <= ST_DN;
          end
        end
        ST_DN: if (dn_done) begin
          dn_req    <= 1'b0;
          rd_hold   <= packed_rd;
          rsp_valid <= 1'b1;
          rsp_data  <= mk_rsp(E_OK, rsp_cnt);
          rsp_last  <= (rsp_cnt == 11'd0);
          widx      <= '0;
          state     <= (rsp_cnt == 11'd0) ? ST_IN : ST_DAT;
        end
        default: begin
          rsp_valid <= 1'b1;
          rsp_data  <= hold_w[widx];
          rsp_last  <= (11'(widx) + 11'd1 == rsp_cnt);
          widx      <= widx + 1'b1;
          if (11'(widx) + 11'd1 == rsp_cnt) state <= ST_IN;
        end
      endcase
    end
  end

  // R10: request stays up until the controller completes
  a_r10_req_holds: assert property (@(posedge clk) disable iff (rst)
    dn_req && !dn_done |=> dn_req);
  // R12: no mailbox word is taken while a request is outstanding
  a_r12_no_take_during_req: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> !in_ready);
  a_r12_last_has_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_last |-> rsp_valid);
  // R9: a write never starts while configuration was busy at the check
  a_r9_busy_blocks_write: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_req) |-> !($past(cfg_busy) && (dn_cmd == OP_WRITE || dn_cmd == OP_WRREG)));
  // R4: forwarded writes are word aligned
  a_r4_write_aligned: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_req) && dn_cmd == OP_WRITE |-> dn_arg0[1:0] == 2'b00);
  // R6: forwarded erases start on a sector boundary
  a_r6_sector_aligned: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_req) && dn_cmd == OP_ERASE |-> dn_arg0[SECT_BITS-1:0] == '0);
endmodule

// File: tb/sim_flash_cmd_validator.sv
module sim_flash_cmd_validator;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, cfg_busy, in_valid, in_last, in_ready;
  logic [31:0] in_data;
  logic        rsp_valid, rsp_last;
  logic [31:0] rsp_data;
  logic        dn_req, dn_done;
  logic [11:0] dn_cmd;
  logic [31:0] dn_arg0, dn_arg1, dn_buf_data;
  logic [63:0] dn_rdata;
  logic [3:0]  dn_buf_addr;

  localparam logic [63:0] RDATA = 64'hF1E2D3C4_B5A69788;

  flash_cmd_validator u0 (
    .clk(clk), .rst(rst), .cfg_busy(cfg_busy), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .dn_req(dn_req), .dn_cmd(dn_cmd), .dn_arg0(dn_arg0),
    .dn_arg1(dn_arg1), .dn_done(dn_done), .dn_rdata(dn_rdata),
    .dn_buf_addr(dn_buf_addr), .dn_buf_data(dn_buf_data)
  );

  typedef struct packed {
    logic [11:0] code; logic [10:0] len; logic [10:0] nsend;
    logic [31:0] a0; logic [31:0] a1; logic busy; logic [10:0] err; logic [10:0] cnt;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{12'h039, 11'd4,  11'd4,  32'h100,   32'd2,      1'b0, 11'h000, 11'd0},
    '{12'h039, 11'd3,  11'd3,  32'h102,   32'd1,      1'b0, 11'h3FF, 11'd0},
    '{12'h039, 11'd3,  11'd3,  32'h0,     32'd1,      1'b1, 11'h104, 11'd0},
    '{12'h039, 11'd3,  11'd3,  32'h0,     32'd17,     1'b0, 11'h105, 11'd0},
    '{12'h039, 11'd3,  11'd3,  32'h0,     32'd2,      1'b0, 11'h100, 11'd0},
    '{12'h038, 11'd3,  11'd2,  32'h0,     32'h4000,   1'b0, 11'h100, 11'd0},
    '{12'h038, 11'd2,  11'd2,  32'h30000, 32'h8000,   1'b0, 11'h000, 11'd0},
    '{12'h038, 11'd2,  11'd2,  32'h18000, 32'h4000,   1'b0, 11'h101, 11'd0},
    '{12'h038, 11'd2,  11'd2,  32'h0,     32'h4001,   1'b0, 11'h102, 11'd0},
    '{12'h038, 11'd2,  11'd2,  32'h0,     32'h0,      1'b0, 11'h102, 11'd0},
    '{12'h037, 11'd2,  11'd2,  32'h0,     32'h0,      1'b0, 11'h3FF, 11'd0},
    '{12'h035, 11'd2,  11'd2,  32'h9F,    32'd5,      1'b0, 11'h000, 11'd2},
    '{12'h035, 11'd2,  11'd2,  32'h05,    32'd3,      1'b0, 11'h000, 11'd1},
    '{12'h035, 11'd2,  11'd2,  32'h05,    32'd9,      1'b0, 11'h103, 11'd0},
    '{12'h035, 11'd2,  11'd2,  32'h05,    32'd8,      1'b0, 11'h000, 11'd2},
    '{12'h036, 11'd4,  11'd4,  32'h06,    32'd6,      1'b0, 11'h000, 11'd0},
    '{12'h036, 11'd3,  11'd3,  32'h06,    32'd6,      1'b0, 11'h100, 11'd0},
    '{12'h036, 11'd4,  11'd4,  32'h06,    32'd6,      1'b1, 11'h104, 11'd0},
    '{12'h038, 11'd2,  11'd2,  32'h0,     32'h4000,   1'b1, 11'h000, 11'd0},
    '{12'h035, 11'd2,  11'd2,  32'h05,    32'd4,      1'b1, 11'h000, 11'd1},
    '{12'h040, 11'd5,  11'd2,  32'h0,     32'h0,      1'b0, 11'h3FF, 11'd0},
    '{12'h039, 11'd3,  11'd3,  32'h1,     32'd1,      1'b1, 11'h104, 11'd0},
    '{12'h039, 11'd18, 11'd18, 32'h0,     32'd16,     1'b0, 11'h000, 11'd0},
    '{12'h036, 11'd2,  11'd2,  32'h06,    32'd0,      1'b0, 11'h103, 11'd0},
    '{12'h039, 11'd2,  11'd2,  32'h0,     32'd1,      1'b0, 11'h100, 11'd0}
  };

  int checks = 0, errs = 0;
  int cur_v = 0;
  logic [31:0] rsp_buf [8];
  int rsp_n;
  bit rsp_gap;
  bit fwd_seen;
  logic [11:0] cap_cmd;
  logic [31:0] cap_a0, cap_a1;
  logic [31:0] cap_buf [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s vec %0d %s: got %h exp %h", req, cur_v, what, act, exp);
    end
  endtask

  function automatic logic [31:0] data_word(input int v, input int k);
    return 32'hA000_0000 | (32'(v) << 8) | 32'(k);
  endfunction

  function automatic logic [31:0] exp_rd(input int j, input int b);
    logic [31:0] r = '0;
    for (int q = 0; q < 4; q++) begin
      if (4*j + q < b) r[8*q +: 8] = RDATA[8*(4*j+q) +: 8];
    end
    return r;
  endfunction

  // downstream controller model
  initial begin
    dn_done = 1'b0;
    dn_rdata = RDATA;
    dn_buf_addr = '0;
    forever begin
      @(negedge clk);
      if (dn_req && !rst) begin
        int nb;
        fwd_seen = 1'b1;
        cap_cmd = dn_cmd; cap_a0 = dn_arg0; cap_a1 = dn_arg1;
        nb = 0;
        if (dn_cmd == 12'h039) nb = (dn_arg1 > 16) ? 16 : int'(dn_arg1);
        if (dn_cmd == 12'h036) nb = (int'(dn_arg1) + 3) / 4;
        for (int j = 0; j < nb; j++) begin
          dn_buf_addr = 4'(j);
          @(negedge clk);
          cap_buf[j] = dn_buf_data;
        end
        repeat (2) @(negedge clk);
        dn_done = 1'b1;
        @(negedge clk);
        dn_done = 1'b0;
      end
    end
  end

  task automatic run_cmd(input int v, input vec_t t);
    int nw;
    logic [31:0] w;
    cur_v = v;
    fwd_seen = 1'b0;
    rsp_n = 0;
    rsp_gap = 1'b0;
    cfg_busy = t.busy;
    nw = int'(t.nsend) + 1;
    for (int i = 0; i < nw; i++) begin
      if (i == 0)      w = {9'b0, t.len, t.code};
      else if (i == 1) w = t.a0;
      else if (i == 2) w = t.a1;
      else             w = data_word(v, i - 1);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = w; in_last = (i == nw - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk(in_ready == 1'b0, "R12", "ready after last", 64'(in_ready), 64'd0);
    for (int c = 0; c < 80; c++) begin
      if (rsp_valid) begin
        if (rsp_n < 8) rsp_buf[rsp_n] = rsp_data;
        rsp_n++;
        if (rsp_last) break;
      end else if (rsp_n > 0) rsp_gap = 1'b1;
      @(negedge clk);
    end
    cfg_busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_vec(input int v, input vec_t t);
    logic [31:0] eh;
    eh = {9'b0, t.cnt, 1'b0, t.err};
    // R1 R2 R3 R4 R5 R6 R7 R8 R9: header word carries the expected code
    chk(rsp_n >= 1 && rsp_buf[0] == eh, "R1", "response header", 64'(rsp_buf[0]), 64'(eh));
    chk(rsp_n == int'(t.cnt) + 1 && !rsp_gap, "R12", "response length", 64'(rsp_n), 64'(t.cnt) + 1);
    chk(fwd_seen == (t.err == 11'h0), "R10", "forwarded", 64'(fwd_seen), 64'(t.err == 11'h0));
    if (fwd_seen && t.err == 11'h0) begin
      chk(cap_cmd == t.code && cap_a0 == t.a0 && cap_a1 == t.a1, "R10", "dn fields",
          {cap_cmd, cap_a1[19:0], cap_a0}, {t.code, t.a1[19:0], t.a0});
      if (t.code == 12'h039 || t.code == 12'h036) begin
        int nb = (t.code == 12'h039) ? int'(t.a1) : (int'(t.a1) + 3) / 4;
        for (int j = 0; j < nb; j++)
          chk(cap_buf[j] == data_word(v, j + 2), "R10", "buffer word", 64'(cap_buf[j]), 64'(data_word(v, j + 2)));
      end
      if (t.code == 12'h035) begin
        for (int j = 0; j < int'(t.cnt); j++)
          chk(rsp_buf[j+1] == exp_rd(j, int'(t.a1)), "R11", "read word",
              64'(rsp_buf[j+1]), 64'(exp_rd(j, int'(t.a1))));
      end
    end
  endtask

  initial begin
    rst = 1'b1; cfg_busy = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready && !rsp_valid && !dn_req, "R12", "reset state",
        {61'd0, in_ready, rsp_valid, dn_req}, 64'd4);

    for (int v = 0; v < NV; v++) begin
      run_cmd(v, VECS[v]);
      check_vec(v, VECS[v]);
    end

    // reset in the middle of a command, then a 2-byte register read (R11, R3)
    begin
      vec_t t;
      cur_v = 100;
      @(negedge clk);
      in_valid = 1'b1; in_data = {9'b0, 11'd2, 12'h035}; in_last = 1'b0;
      @(negedge clk);
      in_data = 32'h5;
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      t = '{12'h035, 11'd2, 11'd2, 32'h05, 32'd2, 1'b0, 11'h000, 11'd1};
      run_cmd(100, t);
      check_vec(100, t);
      chk(rsp_buf[1] == 32'h0000_9788, "R11", "two-byte pad", 64'(rsp_buf[1]), 64'h9788);
      // single byte read: three zero pad bytes
      t = '{12'h035, 11'd2, 11'd2, 32'h05, 32'd1, 1'b0, 11'h000, 11'd1};
      run_cmd(101, t);
      check_vec(101, t);
      chk(rsp_buf[1] == 32'h0000_0088, "R11", "one-byte pad", 64'(rsp_buf[1]), 64'h88);
      // reserved header bits set on an otherwise valid erase (R2)
      cur_v = 102;
      t = '{12'h038, 11'd2, 11'd2, 32'h0, 32'h4000, 1'b0, 11'h3FF, 11'd0};
      fwd_seen = 1'b0;
      @(negedge clk);
      in_valid = 1'b1; in_data = {9'h1, 11'd2, 12'h038}; in_last = 1'b0;
      @(negedge clk); in_data = 32'h0;
      @(negedge clk); in_data = 32'h4000; in_last = 1'b1;
      @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
      @(negedge clk);
      chk(rsp_valid && rsp_data == 32'h0000_03FF && !fwd_seen, "R2", "reserved bits",
          64'(rsp_data), 64'h3FF);
      @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule